// File: doc/BRIEF.md
# Majority-Vote Strobe Sampler

This block turns noisy per-lane training status into one pass/fail bit per byte lane during strobe training. After a start pulse it walks the active lane groups in order, two lanes per group. For every sample it sends one request to an external memory test engine and waits for that engine's completion handshake. It then captures the engine's status word and adds the two status bits that belong to the current group into per-lane ones counters.

After SAMPLE_SIZE captures for a group, each lane of the group is decided by strict majority and written into the lane result vector. The training mode decides two things: which status bits are extracted, and whether the test operation is a read or a write. A flag marks only the very first test operation of a run so the engine can do its one-time setup. When every active group has been voted, a one-cycle done pulse is raised, and the result vector holds until the next start.

Top module: `strobe_vote_sampler`

## Requirements
- R1: After reset, req_o, first_o and done_o are 0 and lanes_o is all zeros.
- R2: Every sample issues exactly one one-cycle req_o pulse, so a run with E effective groups issues E*SAMPLE_SIZE requests. A completion on done_i is taken only while a request is outstanding (the cycles after a req_o pulse). A completion in the req_o cycle itself, or while idle, is ignored.
- R3: With mode_wr_i=0 (receive-enable), the even lane of a group uses status_i bit 1 and the odd lane uses bit 0. With mode_wr_i=1 (write-strobe), the even lane uses bit 9 and the odd lane uses bit 8.
- R4: A lane result is 1 only when twice its count of ones exceeds SAMPLE_SIZE, that is, when ones outnumber zeros. Otherwise it is 0.
- R5: The result for lane l (0 even, 1 odd) of group g appears at lanes_o bit l+2*g. Bits of groups that were not processed read 0.
- R6: op_write_o is 0 on every request of a receive-enable run and 1 on every request of a write-strobe run.
- R7: first_o is 1 together with the first req_o of a run and 0 on every later request.
- R8: The effective group count is grp_cnt_i, or floor(grp_cnt_i/2) when half_width_i=1, limited to MAX_GROUPS. With zero effective groups, done_o rises in the cycle after start and no request is issued.
- R9: done_o is high for exactly one cycle per run. lanes_o keeps the run's result until the next accepted start.
- R10: start_i is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mode_wr_i | input | 1 | 0 receive-enable, 1 write-strobe |
| half_width_i | input | 1 | 16-bit channel: halves the group count |
| grp_cnt_i | input | GRP_W | Requested number of lane groups |
| status_i | input | STATUS_W | Training status word from the test engine |
| done_i | input | 1 | Test engine completion |
| req_o | output | 1 | One-cycle test operation request |
| op_write_o | output | 1 | Request type: 1 write, 0 read |
| first_o | output | 1 | Marks the first request of a run |
| lanes_o | output | 2*MAX_GROUPS | Voted lane results |
| done_o | output | 1 | One-cycle run completion pulse |

## Verification
The two events that can share a cycle are the request pulse and an engine completion. An engine that holds done_i high at all times presents a completion in every request cycle and throughout idle time. That completion must be skipped, and only the one in the following cycle may be captured. The bench runs every configuration both with this always-done engine and with engines of fixed latency. It judges by the number of requests and by voted results computed from the exact status sequence, so a double-counted or missed capture changes either the request count or a lane bit. A stray start pulse in the middle of each run also checks that no second run is launched.

// File: rtl/svs_pkg.sv
package svs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_VOTE,
    ST_FIN
  } svs_state_e;

  // status bit positions per mode; even lane first
  localparam int unsigned RE_EVEN_BIT = 1;
  localparam int unsigned RE_ODD_BIT  = 0;
  localparam int unsigned WS_EVEN_BIT = 9;
  localparam int unsigned WS_ODD_BIT  = 8;
endpackage

// File: rtl/svs_bit_pick.sv
module svs_bit_pick #(
  parameter int unsigned STATUS_W = 16,
  localparam int unsigned IDX_W = $clog2(STATUS_W)
) (
  input  logic [STATUS_W-1:0] status_i,
  input  logic                mode_wr_i,
  output logic [1:0]          pair_o
);
  import svs_pkg::*;

  logic [IDX_W-1:0] even_idx, odd_idx;

  always_comb begin
    even_idx  = mode_wr_i ? IDX_W'(WS_EVEN_BIT) : IDX_W'(RE_EVEN_BIT);
    odd_idx   = mode_wr_i ? IDX_W'(WS_ODD_BIT)  : IDX_W'(RE_ODD_BIT);
    pair_o[0] = status_i[even_idx];
    pair_o[1] = status_i[odd_idx];
  end
endmodule

// File: rtl/svs_vote_cnt.sv
module svs_vote_cnt #(
  parameter int unsigned SAMPLE_SIZE = 5,
  localparam int unsigned CNT_W = $clog2(SAMPLE_SIZE + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  input  logic bit_i,
  output logic pass_o
);
  logic [CNT_W-1:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             ones_q <= '0;
    else if (clr_i)          ones_q <= '0;
    else if (inc_i && bit_i) ones_q <= ones_q + 1'b1;
  end

  // ones > zeros  <=>  2*ones > SAMPLE_SIZE
  assign pass_o = {ones_q, 1'b0} > (CNT_W + 1)'(SAMPLE_SIZE);
endmodule

// File: rtl/svs_ctrl.sv
module svs_ctrl #(
  parameter int unsigned SAMPLE_SIZE = 5,
  parameter int unsigned MAX_GROUPS  = 2,
  localparam int unsigned CNT_W = $clog2(SAMPLE_SIZE + 1),
  localparam int unsigned GRP_W = $clog2(MAX_GROUPS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             done_i,
  input  logic [GRP_W-1:0] eff_grp_i,
  output logic             launch_o,
  output logic             req_o,
  output logic             first_o,
  output logic             capture_o,
  output logic             vote_o,
  output logic             fin_o,
  output logic [GRP_W-1:0] grp_o
);
  import svs_pkg::*;

  svs_state_e       state_q;
  logic [CNT_W-1:0] smp_q;
  logic [GRP_W-1:0] grp_q, ngrp_q;
  logic             first_q;

  assign launch_o  = (state_q == ST_IDLE) && start_i;
  assign req_o     = (state_q == ST_ISSUE);
  assign first_o   = req_o && first_q;
  assign capture_o = (state_q == ST_WAIT) && done_i;
  assign vote_o    = (state_q == ST_VOTE);
  assign fin_o     = (state_q == ST_FIN);
  assign grp_o     = grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      smp_q   <= '0;
      grp_q   <= '0;
      ngrp_q  <= '0;
      first_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          smp_q   <= '0;
          grp_q   <= '0;
          ngrp_q  <= eff_grp_i;
          first_q <= 1'b1;
          state_q <= (eff_grp_i == '0) ? ST_FIN : ST_ISSUE;
        end
        ST_ISSUE: begin
          first_q <= 1'b0;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (done_i) begin
          if (smp_q == CNT_W'(SAMPLE_SIZE - 1)) begin
            smp_q   <= '0;
            state_q <= ST_VOTE;
          end else begin
            smp_q   <= smp_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_VOTE: begin
          if (grp_q == ngrp_q - 1'b1) begin
            state_q <= ST_FIN;
          end else begin
            grp_q   <= grp_q + 1'b1;
            state_q <= ST_ISSUE;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strobe_vote_sampler.sv
module strobe_vote_sampler #(
  parameter int unsigned SAMPLE_SIZE = 5,
  parameter int unsigned MAX_GROUPS  = 2,
  parameter int unsigned STATUS_W    = 16,
  localparam int unsigned GRP_W  = $clog2(MAX_GROUPS + 1),
  localparam int unsigned LANE_N = 2 * MAX_GROUPS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                mode_wr_i,
  input  logic                half_width_i,
  input  logic [GRP_W-1:0]    grp_cnt_i,
  input  logic [STATUS_W-1:0] status_i,
  input  logic                done_i,
  output logic                req_o,
  output logic                op_write_o,
  output logic                first_o,
  output logic [LANE_N-1:0]   lanes_o,
  output logic                done_o
);
  logic [GRP_W-1:0]  req_grp, eff_grp, grp_idx;
  logic              launch, capture, vote, fin;
  logic              mode_q;
  logic [1:0]        pair, pass;
  logic [LANE_N-1:0] res_q;

  always_comb begin
    req_grp = half_width_i ? (grp_cnt_i >> 1) : grp_cnt_i;
    eff_grp = (req_grp > GRP_W'(MAX_GROUPS)) ? GRP_W'(MAX_GROUPS) : req_grp;
  end

  svs_ctrl #(.SAMPLE_SIZE(SAMPLE_SIZE), .MAX_GROUPS(MAX_GROUPS)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .done_i,
    .eff_grp_i (eff_grp),
    .launch_o  (launch),
    .req_o     (req_o),
    .first_o   (first_o),
    .capture_o (capture),
    .vote_o    (vote),
    .fin_o     (fin),
    .grp_o     (grp_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= 1'b0;
    else if (launch) mode_q <= mode_wr_i;
  end

  svs_bit_pick #(.STATUS_W(STATUS_W)) u_pick (
    .status_i, .mode_wr_i(mode_q), .pair_o(pair)
  );

  for (genvar l = 0; l < 2; l++) begin : g_lane
    svs_vote_cnt #(.SAMPLE_SIZE(SAMPLE_SIZE)) u_cnt (
      .clk_i, .rst_ni,
      .clr_i  (launch || vote),
      .inc_i  (capture),
      .bit_i  (pair[l]),
      .pass_o (pass[l])
    );
  end

  for (genvar g = 0; g < MAX_GROUPS; g++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              res_q[2*g +: 2] <= '0;
      else if (launch)                          res_q[2*g +: 2] <= '0;
      else if (vote && grp_idx == GRP_W'(g))    res_q[2*g +: 2] <= pass;
    end
  end

  assign op_write_o = mode_q;
  assign lanes_o    = res_q;
  assign done_o     = fin;
endmodule

// File: rtl/svs_checker.sv
module svs_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_o,
  input logic first_o,
  input logic done_o
);
  a_r2_req_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);
  a_r7_first_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |-> req_o);
  a_r7_first_not_repeated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_o |=> !first_o);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_done_not_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && req_o));
endmodule

bind strobe_vote_sampler svs_checker u_svs_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_o   (req_o),
  .first_o (first_o),
  .done_o  (done_o)
);

// File: tb/strobe_vote_sampler_bench.sv
`timescale 1ns/1ps
module strobe_vote_sampler_bench;
  localparam int S    = 5;
  localparam int MAXG = 2;
  localparam int GW   = $clog2(MAXG + 1);
  localparam int LN   = 2 * MAXG;

  logic clk = 0, rst_ni = 0;
  logic start_i = 0, mode_wr_i = 0, half_width_i = 0, done_i = 0;
  logic [GW-1:0] grp_cnt_i = '0;
  logic [15:0] status_i = '0;
  logic req_o, op_write_o, first_o, done_o;
  logic [LN-1:0] lanes_o;

  always #5 clk = ~clk;

  strobe_vote_sampler #(.SAMPLE_SIZE(S), .MAX_GROUPS(MAXG), .STATUS_W(16)) u_strobe_vote_sampler (
    .clk_i(clk), .rst_ni, .start_i, .mode_wr_i, .half_width_i, .grp_cnt_i,
    .status_i, .done_i, .req_o, .op_write_o, .first_o, .lanes_o, .done_o);

  int n_chk = 0, n_bad = 0;
  int hold = 0, lat = 1, seed = 0, cur_mode = 0;
  int pend = 0, pend_k = 0, req_n = 0, first_n = 0, first_late = 0, op_bad = 0;

  function automatic logic [15:0] stat(int sd, int k);
    int j;
    logic [15:0] w;
    j = k % S;
    w = '0;
    case (sd)
      0: begin w[1] = (j <= S/2); w[9] = (j <= S/2); w[0] = (j < S/2); w[8] = (j < S/2); end
      1: begin w[1] = (j < S/2); w[9] = (j < S/2); w[0] = (j >= S/2); w[8] = (j >= S/2); end
      default: begin
        w = 16'(k * 40503 + sd * 32586);
        w = w ^ (w >> 7) ^ 16'(k << 9);
      end
    endcase
    return w;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // test engine model
  always @(negedge clk) begin
    if (!hold) done_i = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin done_i = 1; status_i = stat(seed, pend_k); end
    end
    if (rst_ni && req_o) begin
      if (first_o) begin first_n++; if (req_n != 0) first_late++; end
      if (int'(op_write_o) != cur_mode) op_bad++;
      if (hold) status_i = stat(seed, req_n);
      else begin pend = lat; pend_k = req_n; end
      req_n++;
    end
  end

  task automatic run(int mode, int gc, int half, int lt, int sd);
    int eff, cyc, ones, bitpos;
    logic [LN-1:0] exp_l, held;
    eff = half ? gc / 2 : gc;
    if (eff > MAXG) eff = MAXG;
    exp_l = '0;
    for (int g = 0; g < eff; g++)
      for (int l = 0; l < 2; l++) begin
        ones = 0;
        bitpos = mode ? (l ? 8 : 9) : (l ? 0 : 1);
        for (int j = 0; j < S; j++) ones += int'(stat(sd, g * S + j)[bitpos]);
        exp_l[l + 2 * g] = (2 * ones > S);
      end
    @(negedge clk);
    hold = (lt == 0); lat = lt; seed = sd; cur_mode = mode;
    done_i = hold[0];
    req_n = 0; first_n = 0; first_late = 0; op_bad = 0;
    mode_wr_i = mode[0]; half_width_i = half[0]; grp_cnt_i = GW'(gc);
    start_i = 1;
    @(negedge clk);
    start_i = 0;
    cyc = 1;
    while (!done_o && cyc < 2000) begin
      start_i = (cyc == 3);  // stray start while busy (R10)
      @(negedge clk);
      cyc++;
    end
    start_i = 0;
    chk(done_o, "R9 done seen", int'(done_o), 1);
    chk(lanes_o == exp_l, "R3/R4/R5 lanes", int'(lanes_o), int'(exp_l));
    chk(req_n == eff * S, "R2 request count", req_n, eff * S);
    chk(first_n == (eff > 0 ? 1 : 0) && first_late == 0, "R7 first flag", first_n, eff > 0 ? 1 : 0);
    chk(op_bad == 0, "R6 op type", op_bad, 0);
    if (eff == 0) chk(cyc == 1, "R8 empty run latency", cyc, 1);
    held = lanes_o;
    @(negedge clk);
    chk(!done_o, "R9 done width", int'(done_o), 0);
    repeat (3) @(negedge clk);
    chk(lanes_o == held, "R9 lanes hold", int'(lanes_o), int'(held));
    chk(req_n == eff * S, "R10 no relaunch", req_n, eff * S);
    hold = 0; done_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!req_o && !first_o && !done_o, "R1 reset ctrl", int'({req_o, first_o, done_o}), 0);
    chk(lanes_o == '0, "R1 reset lanes", int'(lanes_o), 0);
    rst_ni = 1;
    for (int m = 0; m < 2; m++)
      for (int gc = 0; gc < 4; gc++)
        for (int h = 0; h < 2; h++)
          for (int lt = 0; lt < 3; lt++)
            for (int sd = 0; sd < 4; sd++)
              run(m, gc, h, lt == 2 ? 3 : lt, sd);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule